// File: doc/BRIEF.md
# Multi-Ratio Clock Post-Divider

This block sits behind a high-frequency source clock and produces a slower clock whose ratio is picked from a fixed, irregular menu. A small code selects the entry. The output keeps a 50% duty cycle for every ratio, odd ratios included. For an odd ratio the divider stretches its high phase by half a source cycle, using a flop clocked on the falling edge. Ratio 1 passes the source clock through a glitch-free gate.

Several instances with different menus can feed a downstream routing multiplexer. A build parameter chooses the menu: the full eighteen-entry menu, or one of the short menus {1,2,4}, {1,2,4,8} and {2,3,4}. A new code is taken only at the boundary between output periods. While the enable is low, the output is held low and the period counter is cleared. When the enable returns, the output starts a fresh full period.

Top module: `clkdiv_post`

## Requirements
- R1: With the default full menu, codes 0 through 17 select the ratios 1, 2, 3, 4, 5, 6, 8, 10, 12, 13, 20, 24, 26, 40, 48, 52, 96, 104 in that order.
- R2: Any code beyond the last menu entry (18 to 31 for the full menu) selects divide-by-1.
- R3: For ratio N, the output repeats every N source cycles, which is 2N source half-cycles.
- R4: For an even ratio N, the output is high for exactly N/2 source cycles of each period.
- R5: For an odd ratio N greater than 1, the output is high for N source half-cycles of each period. It rises with a source rising edge and falls on a source falling edge.
- R6: For ratio 1, the output is high during the high phase of the source clock and low during its low phase.
- R7: A code change during a period does not alter that period. The new ratio governs the period that begins after it.
- R8: While the enable is low, the output stays low and the period counter is held at zero.
- R9: The first source rising edge that samples the enable high starts a full period. For a ratio above 1, the output is high in the half-cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Divider enable; low holds the output low |
| code_i | input | 5 | Ratio-select code indexing the menu |
| clk_o | output | 1 | Divided clock output |

## Verification
The bench samples the output once in every source half-cycle. It then counts high and low half-cycles per period for every menu entry. A missing half-cycle stretch would show 2 of 6 high slots at ratio 3, and an off-by-one terminal count would show a wrong period. Unused codes are driven to catch a design that falls through to a stale or zero ratio. A code switch is made in the middle of a divide-by-8 period: a design that reloads early would cut that period short. Disabling and re-enabling the divider checks that the output stays low and that the first period is full length, not a leftover fragment.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    typedef enum logic [1:0] {
        MENU_FULL  = 2'd0,
        MENU_POW3  = 2'd1,
        MENU_POW4  = 2'd2,
        MENU_MIX3  = 2'd3
    } menu_e;

    // Number of valid codes in each menu variant.
    function automatic int menu_len(menu_e kind);
        case (kind)
            MENU_FULL: return 18;
            MENU_POW3: return 3;
            MENU_POW4: return 4;
            default:   return 3;
        endcase
    endfunction

    // Full menu ratio for a code; 1 outside the menu.
    function automatic int full_ratio(int idx);
        case (idx)
            0:  return 1;
            1:  return 2;
            2:  return 3;
            3:  return 4;
            4:  return 5;
            5:  return 6;
            6:  return 8;
            7:  return 10;
            8:  return 12;
            9:  return 13;
            10: return 20;
            11: return 24;
            12: return 26;
            13: return 40;
            14: return 48;
            15: return 52;
            16: return 96;
            17: return 104;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_ratio_rom.sv
`timescale 1ns/1ps
module clkdiv_ratio_rom
    import clkdiv_pkg::*;
#(
    parameter menu_e MENU_KIND = MENU_FULL,
    parameter int    CODE_W    = 5,
    parameter int    RATIO_W   = 7
) (
    input  logic [CODE_W-1:0]  code_i,
    output logic [RATIO_W-1:0] ratio_o
);
    localparam int LEN = menu_len(MENU_KIND);

    generate
        if (MENU_KIND == MENU_FULL) begin : g_full
            always_comb begin
                ratio_o = RATIO_W'(full_ratio(int'(code_i)));
            end
        end else if (MENU_KIND == MENU_MIX3) begin : g_mix
            always_comb begin
                if (int'(code_i) < LEN) ratio_o = RATIO_W'(int'(code_i) + 2);
                else                    ratio_o = RATIO_W'(1);
            end
        end else begin : g_pow
            always_comb begin
                if (int'(code_i) < LEN) ratio_o = RATIO_W'(1) << code_i;
                else                    ratio_o = RATIO_W'(1);
            end
        end
    endgenerate

endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core #(
    parameter int RATIO_W = 7
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               run_o,
    output logic               wrap_o,
    output logic [RATIO_W-1:0] cnt_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               pos_o,
    output logic               odd_o,
    output logic               one_o
);
    typedef struct packed {
        logic               run;
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] ratio;
        logic               pos;
        logic               odd;
        logic               one;
    } core_st_t;

    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    core_st_t st_d, st_q;
    logic [RATIO_W-1:0] half;
    logic [RATIO_W-1:0] cnt_inc;
    logic               wrap;

    always_comb begin
        st_d    = st_q;
        half    = st_q.ratio >> 1;
        cnt_inc = st_q.cnt + ONE;
        wrap    = st_q.run && (cnt_inc == st_q.ratio);
        if (!en_i) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
            st_d.pos = 1'b0;
            st_d.odd = 1'b0;
            st_d.one = 1'b0;
        end else if (!st_q.run || wrap) begin
            st_d.run   = 1'b1;
            st_d.cnt   = '0;
            st_d.ratio = ratio_i;
            st_d.pos   = ratio_i > ONE;
            st_d.odd   = ratio_i[0] && (ratio_i > ONE);
            st_d.one   = ratio_i == ONE;
        end else begin
            st_d.cnt = cnt_inc;
            st_d.pos = cnt_inc < half;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.ratio <= ONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o   = st_q.run;
    assign wrap_o  = wrap;
    assign cnt_o   = st_q.cnt;
    assign ratio_o = st_q.ratio;
    assign pos_o   = st_q.pos;
    assign odd_o   = st_q.odd;
    assign one_o   = st_q.one;

endmodule

// File: rtl/clkdiv_half_stretch.sv
`timescale 1ns/1ps
module clkdiv_half_stretch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pos_i,
    input  logic odd_i,
    input  logic one_i,
    output logic ext_o,
    output logic gate_o
);
    typedef struct packed {
        logic ext;
        logic gate;
    } neg_st_t;

    neg_st_t st_d, st_q;

    always_comb begin
        st_d.ext  = pos_i && odd_i;
        st_d.gate = one_i;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ext_o  = st_q.ext;
    assign gate_o = st_q.gate;

endmodule

// File: rtl/clkdiv_post.sv
`timescale 1ns/1ps
module clkdiv_post
    import clkdiv_pkg::*;
#(
    parameter menu_e MENU_KIND = MENU_FULL,
    parameter int    CODE_W    = 5,
    parameter int    RATIO_W   = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              clk_o
);
    localparam int MENU_LEN = menu_len(MENU_KIND);

    logic [RATIO_W-1:0] rom_ratio;
    logic               run_q;
    logic               wrap;
    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] ratio_q;
    logic               pos_q;
    logic               odd_q;
    logic               one_q;
    logic               ext_q;
    logic               gate_q;

    clkdiv_ratio_rom #(
        .MENU_KIND (MENU_KIND),
        .CODE_W    (CODE_W),
        .RATIO_W   (RATIO_W)
    ) u_rom (
        .code_i  (code_i),
        .ratio_o (rom_ratio)
    );

    clkdiv_core #(
        .RATIO_W (RATIO_W)
    ) u_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .ratio_i (rom_ratio),
        .run_o   (run_q),
        .wrap_o  (wrap),
        .cnt_o   (cnt_q),
        .ratio_o (ratio_q),
        .pos_o   (pos_q),
        .odd_o   (odd_q),
        .one_o   (one_q)
    );

    clkdiv_half_stretch u_stretch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pos_i  (pos_q),
        .odd_i  (odd_q),
        .one_i  (one_q),
        .ext_o  (ext_q),
        .gate_o (gate_q)
    );

    // Gate term changes only while the source is low, so no runt pulse.
    assign clk_o = pos_q | ext_q | (gate_q & clk_i);

endmodule

// File: rtl/clkdiv_post_chk.sv
`timescale 1ns/1ps
module clkdiv_post_chk #(
    parameter int CODE_W   = 5,
    parameter int RATIO_W  = 7,
    parameter int MENU_LEN = 18
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               en_i,
    input logic [CODE_W-1:0]  code_i,
    input logic [RATIO_W-1:0] rom_ratio,
    input logic               run_q,
    input logic               wrap,
    input logic [RATIO_W-1:0] cnt_q,
    input logic [RATIO_W-1:0] ratio_q,
    input logic               pos_q,
    input logic               odd_q,
    input logic               one_q,
    input logic               ext_q
);
    assert_unused_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(code_i) >= MENU_LEN) |-> (rom_ratio == RATIO_W'(1)));

    assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q |-> (cnt_q < ratio_q));

    assert_even_no_stretch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !odd_q |-> !ext_q);

    assert_hold_ratio_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && !wrap) |=> $stable(ratio_q));

    assert_idle_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!pos_q && (cnt_q == '0) && !run_q));

    assert_full_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !run_q) |=> ((pos_q || one_q) && (cnt_q == '0)));

endmodule

bind clkdiv_post clkdiv_post_chk #(
    .CODE_W   (CODE_W),
    .RATIO_W  (RATIO_W),
    .MENU_LEN (MENU_LEN)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .code_i    (code_i),
    .rom_ratio (rom_ratio),
    .run_q     (run_q),
    .wrap      (wrap),
    .cnt_q     (cnt_q),
    .ratio_q   (ratio_q),
    .pos_q     (pos_q),
    .odd_q     (odd_q),
    .one_q     (one_q),
    .ext_q     (ext_q)
);

// File: tb/clkdiv_post_tb.sv
`timescale 1ns/1ps
module clkdiv_post_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [4:0] code = 5'd0;
    logic       clk_out;

    int n_checks = 0;
    int n_bad    = 0;

    localparam int EXP_RATIO [18] = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 13,
                                      20, 24, 26, 40, 48, 52, 96, 104};

    always #2.5 clk = ~clk;

    clkdiv_post u_dut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .en_i   (en),
        .code_i (code),
        .clk_o  (clk_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One sample per source half-cycle, a quarter period after each edge.
    task automatic slot(output logic v);
        @(clk);
        #1.25;
        v = clk_out;
    endtask

    // Wait for a rising output, then count high and low half-cycles.
    task automatic measure(output int hi, output int lo);
        logic v;
        logic prev;
        bit   found;
        hi = 0;
        lo = 0;
        found = 0;
        slot(prev);
        for (int i = 0; i < 1000 && !found; i++) begin
            slot(v);
            if (!prev && v) found = 1;
            prev = v;
        end
        if (!found) return;
        hi = 1;
        for (int i = 0; i < 1000; i++) begin
            slot(v);
            if (!v) break;
            hi++;
        end
        lo = 1;
        for (int i = 0; i < 1000; i++) begin
            slot(v);
            if (v) break;
            lo++;
        end
    endtask

    task automatic t_reset();
        logic v;
        slot(v);
        check("R8 reset output low", int'(v), 0);
        slot(v);
        check("R8 reset output low", int'(v), 0);
    endtask

    task automatic t_menu();
        int hi;
        int lo;
        for (int c = 0; c < 18; c++) begin
            code = 5'(c);
            measure(hi, lo);
            measure(hi, lo);
            if (EXP_RATIO[c] == 1)
                check($sformatf("R1 R6 code %0d high", c), hi, 1);
            else if (EXP_RATIO[c] % 2 == 1)
                check($sformatf("R1 R5 code %0d high", c), hi, EXP_RATIO[c]);
            else
                check($sformatf("R1 R4 code %0d high", c), hi, EXP_RATIO[c]);
            check($sformatf("R3 code %0d period", c), hi + lo, 2 * EXP_RATIO[c]);
        end
    endtask

    task automatic t_unused();
        int hi;
        int lo;
        code = 5'd6;
        measure(hi, lo);
        code = 5'd25;
        measure(hi, lo);
        measure(hi, lo);
        check("R2 code 25 high", hi, 1);
        check("R2 code 25 low", lo, 1);
        code = 5'd31;
        measure(hi, lo);
        measure(hi, lo);
        check("R2 code 31 period", hi + lo, 2);
        code = 5'd18;
        measure(hi, lo);
        measure(hi, lo);
        check("R2 code 18 period", hi + lo, 2);
    endtask

    task automatic t_switch();
        int hi;
        int lo;
        logic v;
        logic prev;
        code = 5'd6;
        measure(hi, lo);
        slot(prev);
        for (int i = 0; i < 200; i++) begin
            slot(v);
            if (!prev && v) break;
            prev = v;
        end
        code = 5'd2;
        hi = 1;
        for (int i = 0; i < 200; i++) begin
            slot(v);
            if (!v) break;
            hi++;
        end
        lo = 1;
        for (int i = 0; i < 200; i++) begin
            slot(v);
            if (v) break;
            lo++;
        end
        check("R7 old period high kept", hi, 8);
        check("R7 old period low kept", lo, 8);
        measure(hi, lo);
        check("R7 new ratio high", hi, 3);
        check("R7 new ratio period", hi + lo, 6);
    endtask

    task automatic t_disable_enable();
        int hi;
        int lo;
        int highs;
        logic v;
        code = 5'd4;
        measure(hi, lo);
        slot(v);
        en = 1'b0;
        for (int i = 0; i < 4; i++) slot(v);
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            slot(v);
            if (v) highs++;
        end
        check("R8 disabled high slots", highs, 0);
        code = 5'd9;
        for (int i = 0; i < 6; i++) slot(v);
        check("R8 code change while disabled keeps low", int'(v), 0);
        for (int i = 0; i < 4; i++) begin
            slot(v);
            if (clk == 1'b0) break;
        end
        en = 1'b1;
        slot(v);
        check("R9 first half-cycle high", int'(v), 1);
        hi = 1;
        for (int i = 0; i < 200; i++) begin
            slot(v);
            if (!v) break;
            hi++;
        end
        lo = 1;
        for (int i = 0; i < 200; i++) begin
            slot(v);
            if (v) break;
            lo++;
        end
        check("R9 first period high", hi, 13);
        check("R9 first period low", lo, 13);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        en = 1'b1;
        t_menu();
        t_unused();
        t_switch();
        t_disable_enable();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule